// File: doc/BRIEF.md
# Double-Buffered Instruction Register

This block holds the current instruction word of a small microcoded processor. On the rising clock edge of the fetch step, a first register takes a 6-bit opcode from the data bus and, alongside it, the zero and carry flags. The flags are sampled at that moment only. A second register follows the first and copies it on every falling clock edge. The second register drives the high part of the microcode ROM address, so those address lines can only move on a falling edge.

The buffered 8 bits are joined to the 4-bit microinstruction step count to form a 12-bit microcode address. Reset does not clear the register. After power-up its contents are unknown until the first fetch loads it. Logic downstream that combines ROM outputs with the high phase of the clock therefore sees an address that holds steady through every rising edge.

Top module: `instr_reg_dbuf`

## Requirements
- R1: On a rising clock edge with `ir_wr` high, the first stage loads a word whose bits [5:0] are `bus_opc`, bit [6] is `flag_zero` and bit [7] is `flag_carry`.
- R2: On a rising clock edge with `ir_wr` low, the first stage keeps its value, whatever `bus_opc`, `flag_zero` and `flag_carry` do.
- R3: `ir_rom_bits` takes the first-stage value on each falling clock edge and does not change at a rising edge. A word loaded at a rising edge first appears at the output after the next falling edge.
- R4: `uaddr` is `ir_rom_bits` in bits [11:4] and `step_cnt` in bits [3:0]. The step bits follow `step_cnt` without any register.
- R5: `rst` neither clears the register nor stops a load. With `rst` high and `ir_wr` low, the value is held. With `rst` high and `ir_wr` high, the load still happens.
- R6: Each of the 64 opcode values 0 to 63 appears unchanged in `uaddr[9:4]` after it is loaded.
- R7: Flag changes between loads have no effect on `uaddr[11:10]`. Those bits show the flags as they were at the most recent load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; loads on the rising edge, buffer copies on the falling edge |
| rst | input | 1 | Active-high system reset; does not clear this register |
| ir_wr | input | 1 | Instruction load enable |
| bus_opc | input | 6 | Opcode slice of the data bus |
| flag_zero | input | 1 | Zero flag from the ALU flags register |
| flag_carry | input | 1 | Carry flag from the ALU flags register |
| step_cnt | input | 4 | Microinstruction step count |
| ir_rom_bits | output | 8 | Buffered instruction word driving the ROM address |
| uaddr | output | 12 | Full microcode ROM address |

## Verification
On every cycle, the assertions check four things: the first stage takes the {carry, zero, opcode} word when a load is enabled; it holds its value when no load is enabled; the buffer equals the first stage at each falling edge; and the buffered output matches the first stage at each rising edge, so it has not moved since the last falling edge. Some behaviours only the bench scenarios can show. These are the delay of one falling edge between a load and its appearance at the output, loads and holds while reset is high, flags that toggle with no load, the full sweep of 64 opcodes, and step bits that track a changing step count. Before reset is released the bench loads a known word, so no check or assertion ever sees the undefined power-up value.

// File: rtl/ir_dbuf_pkg.sv
package ir_dbuf_pkg;

    localparam int OPC_W  = 6;
    localparam int STEP_W = 4;
    localparam int IRW_W  = OPC_W + 2;
    localparam int ADDR_W = IRW_W + STEP_W;

    typedef struct packed {
        logic             carry;
        logic             zero;
        logic [OPC_W-1:0] opcode;
    } ir_word_t;

    function automatic ir_word_t make_word(input logic [OPC_W-1:0] opc,
                                           input logic zf,
                                           input logic cf);
        ir_word_t w;
        w.carry  = cf;
        w.zero   = zf;
        w.opcode = opc;
        return w;
    endfunction

endpackage

// File: rtl/ir_capture.sv
module ir_capture
    import ir_dbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OPC_W-1:0] opc_in,
    input  logic             zf_in,
    input  logic             cf_in,
    output ir_word_t         word_q
);

    // Rising-edge stage; deliberately has no reset term.
    always_ff @(posedge clk) begin
        if (load)
            word_q <= make_word(opc_in, zf_in, cf_in);
    end

    // R1: a load takes the bus opcode and the flags present at that edge
    p_load_word_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (word_q == {$past(cf_in), $past(zf_in), $past(opc_in)}));

    // R2, R7: without a load, nothing on the inputs moves the stage
    p_hold_word_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q));

endmodule

// File: rtl/ir_fall_buffer.sv
module ir_fall_buffer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            always_ff @(negedge clk) begin
                dst[b] <= src[b];
            end
        end
    endgenerate

    // R3: each falling edge presents what the source held at the one before
    p_fall_copy_r3: assert property (@(negedge clk) disable iff (rst)
        dst == $past(src));

endmodule

// File: rtl/uaddr_join.sv
module uaddr_join #(
    parameter int HI_W = 8,
    parameter int LO_W = 4,
    localparam int OUT_W = HI_W + LO_W
) (
    input  logic [HI_W-1:0]  hi,
    input  logic [LO_W-1:0]  lo,
    output logic [OUT_W-1:0] addr
);

    always_comb begin
        addr[LO_W-1:0]     = lo;
        addr[OUT_W-1:LO_W] = hi;
    end

endmodule

// File: rtl/instr_reg_dbuf.sv
module instr_reg_dbuf
    import ir_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ir_wr,
    input  logic [OPC_W-1:0]  bus_opc,
    input  logic              flag_zero,
    input  logic              flag_carry,
    input  logic [STEP_W-1:0] step_cnt,
    output logic [IRW_W-1:0]  ir_rom_bits,
    output logic [ADDR_W-1:0] uaddr
);

    ir_word_t stage1;

    ir_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .load   (ir_wr),
        .opc_in (bus_opc),
        .zf_in  (flag_zero),
        .cf_in  (flag_carry),
        .word_q (stage1)
    );

    ir_fall_buffer #(.WIDTH(IRW_W)) u_buf (
        .clk (clk),
        .rst (rst),
        .src (stage1),
        .dst (ir_rom_bits)
    );

    uaddr_join #(.HI_W(IRW_W), .LO_W(STEP_W)) u_join (
        .hi   (ir_rom_bits),
        .lo   (step_cnt),
        .addr (uaddr)
    );

    // R3: just before each rising edge the output already matches stage 1, so the ROM address cannot move there
    p_no_rise_move_r3: assert property (@(posedge clk) disable iff (rst)
        ir_rom_bits == stage1);

endmodule

// File: tb/instr_reg_dbuf_test.sv
`timescale 1ns/1ps
module instr_reg_dbuf_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ir_wr;
    logic [5:0]  bus_opc;
    logic        flag_zero;
    logic        flag_carry;
    logic [3:0]  step_cnt;
    logic [7:0]  ir_rom_bits;
    logic [11:0] uaddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference: value loaded at the rising edge, value shown after the falling edge
    int ref_loaded;
    int ref_shown;

    always #2 clk = ~clk;

    instr_reg_dbuf uut (
        .clk(clk), .rst(rst), .ir_wr(ir_wr), .bus_opc(bus_opc),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .step_cnt(step_cnt),
        .ir_rom_bits(ir_rom_bits), .uaddr(uaddr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: inputs are set mid-high phase, checked after the falling and the rising edge.
    task automatic cycle(input string req, input bit wr, input int opc,
                         input bit z, input bit c, input int stp);
        ir_wr      = wr;
        bus_opc    = opc[5:0];
        flag_zero  = z;
        flag_carry = c;
        step_cnt   = stp[3:0];
        @(negedge clk);
        ref_shown = ref_loaded;
        #1;
        check({req, " after fall"}, int'(uaddr), (ref_shown << 4) | (stp & 15));
        @(posedge clk);
        if (wr) ref_loaded = (int'(c) << 7) | (int'(z) << 6) | (opc & 63);
        #1;
        check({req, " after rise"}, int'(ir_rom_bits), ref_shown);
    endtask

    initial begin
        rst = 1'b1; ir_wr = 1'b1; bus_opc = 6'h15; flag_zero = 1'b1;
        flag_carry = 1'b0; step_cnt = 4'd0;
        @(posedge clk);
        ref_loaded = 8'h55;
        @(negedge clk);
        ref_shown = ref_loaded;
        @(posedge clk);
        #1;
        // R5: load while reset is high takes effect
        check("R5 load during reset", int'(ir_rom_bits), 8'h55);
        ir_wr = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R5 reset does not clear", int'(ir_rom_bits), 8'h55);

        // R1, R3: new words, visible only after the falling edge
        cycle("R1 load a", 1, 6'h2a, 0, 1, 1);
        cycle("R3 delay a", 0, 6'h00, 0, 0, 2);
        cycle("R1 load b", 1, 6'h3f, 1, 1, 3);
        cycle("R1 load c", 1, 6'h01, 0, 0, 4);
        cycle("R3 delay c", 0, 6'h11, 1, 1, 5);

        // R2, R7: bus and flags toggle with no load
        for (int k = 0; k < 8; k++)
            cycle("R7 flags ignored", 0, k * 9, k[0], k[1], k);
        check("R2 hold after toggles", int'(uaddr[11:4]), 8'h01);

        // R4: step bits follow step_cnt
        for (int s = 0; s < 16; s++)
            cycle("R4 step field", 0, 6'h3c, 1, 0, s);

        // R5: reset high, no load, value held
        rst = 1'b1;
        cycle("R5 held in reset", 0, 6'h22, 1, 1, 7);
        cycle("R5 held in reset 2", 0, 6'h22, 1, 1, 8);
        cycle("R5 load in reset", 1, 6'h0e, 1, 0, 9);
        cycle("R5 loaded in reset", 0, 6'h00, 0, 0, 9);
        rst = 1'b0;

        // R6: all opcodes, flags varied
        for (int op = 0; op < 64; op++) begin
            cycle("R6 sweep load", 1, op, op[2], op[3], op & 15);
            cycle("R6 sweep show", 0, 63 - op, ~op[2], ~op[3], 15 - (op & 15));
            check("R6 opcode field", int'(uaddr[9:4]), op);
            check("R7 flag field", int'(uaddr[11:10]), (op >> 2) & 3);
        end

        // R1: back-to-back loads
        cycle("R1 b2b 1", 1, 6'h05, 1, 1, 0);
        cycle("R1 b2b 2", 1, 6'h06, 0, 1, 0);
        cycle("R1 b2b 3", 0, 6'h07, 1, 0, 0);
        check("R1 b2b final", int'(ir_rom_bits), 8'h86);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule